// File: doc/BRIEF.md
# Triggered circular trace capture buffer

This block records a stream of 32-bit trace words into an on-chip RAM that is used as a ring. While capture is enabled, every word offered with a valid strobe is stored at the write pointer, which then advances and wraps modulo the depth. A sticky full flag shows that the ring has wrapped and that the oldest words have been overwritten.

A trigger pulse marks the point of interest. From the cycle in which the trigger is seen, every stored word counts a post-trigger counter down. When the counter is used up, capture switches itself off, an acquisition-complete flag is raised and, one cycle later, a flushed flag tells software that no word is still on its way into the RAM.

Software reaches the block through a small register port: nine 32-bit registers with constants, status, pointers, the counter and a control word. Reading the data register with the read strobe returns the word at the read pointer and steps the pointer, so a whole trace can be drained by repeated reads of one address.

Top module: `trace_ring_buffer`

## Requirements
- R1: Address 0 reads the identification constant (parameter ID_VALUE), address 1 reads the depth (16 by default) and address 2 reads the word width (32); writes to these three addresses change nothing, and every address from 9 upward reads 0.
- R2: Control register (address 8): bit 0 enables capture and bit 1 holds the demultiplexed-mode selection, both read back in the same positions. A word is stored only in a cycle where capture is enabled and the valid strobe is high; writing 0 to control stops capture.
- R3: Each stored word goes to the RAM slot named by the write pointer (address 6), which then advances by one modulo the depth; a write to address 6 loads the pointer and takes precedence over the advance in the same cycle.
- R4: Status (address 3) bit 0 is a sticky full flag, set when a word is stored at slot depth-1.
- R5: A read of address 4 with the read strobe returns the word at the read pointer (address 5) and advances the pointer by one modulo the depth; a read strobe at any other address leaves the pointer unchanged, and a write to address 5 loads it.
- R6: Status bit 1 is set by a trigger pulse seen while capture is enabled; a trigger while disabled has no effect.
- R7: Once triggered, every stored word (including one stored in the trigger cycle) decrements the trigger counter (address 7, writable). The word that takes the counter from 1 to 0 is stored, capture is disabled and status bit 2 is set; if the counter is already 0 when armed, capture stops in that cycle without storing.
- R8: Status bit 3 (flushed) rises exactly one cycle after status bit 2.
- R9: Writing control with bit 0 set while capture is disabled clears all four status flags.
- R10: When a data-register read and a store to the same slot fall in one cycle, the read returns the word held before that store, and both the store and the pointer step take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Trace word valid strobe |
| cap_data | input | DATA_W | Trace word |
| cap_trigger | input | 1 | Trigger pulse |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (steps the read pointer on address 4) |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
The sharpest overlap is a software read of the data register landing in the same cycle as a capture store into the slot under the read pointer. The bench sets both pointers to one slot, enables capture, and in one cycle offers a word while reading address 4; it expects the older word back, then checks that the read pointer and write pointer have both moved on and that a re-read of the slot shows the new word. The random phase keeps capture, triggers and register traffic running in the same cycles, so pointer loads against advances and counter writes against decrements are judged there by a reference model.

// File: rtl/trb_pkg.sv
package trb_pkg;

  localparam int unsigned REG_AW = 7;

  localparam logic [REG_AW-1:0] A_IDENT   = 7'd0;
  localparam logic [REG_AW-1:0] A_DEPTH   = 7'd1;
  localparam logic [REG_AW-1:0] A_WIDTH   = 7'd2;
  localparam logic [REG_AW-1:0] A_STATUS  = 7'd3;
  localparam logic [REG_AW-1:0] A_DATA    = 7'd4;
  localparam logic [REG_AW-1:0] A_RDPTR   = 7'd5;
  localparam logic [REG_AW-1:0] A_WRPTR   = 7'd6;
  localparam logic [REG_AW-1:0] A_TRIGCNT = 7'd7;
  localparam logic [REG_AW-1:0] A_CTRL    = 7'd8;

  // advance a ring index; depth is a power of two
  function automatic logic [31:0] ring_step(input logic [31:0] p, input int unsigned depth);
    return (p + 32'd1) & 32'(depth - 1);
  endfunction

  // status word: bit0 full, bit1 triggered, bit2 complete, bit3 flushed
  function automatic logic [31:0] pack_status(input logic full, input logic trig,
                                              input logic acq, input logic flush);
    return {28'd0, flush, acq, trig, full};
  endfunction

endpackage

// File: rtl/trb_ring_ram.sv
module trb_ring_ram #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/trb_pointers.sv
module trb_pointers #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_evt,
  input  logic          rd_adv_evt,
  input  logic          wp_wr,
  input  logic          rp_wr,
  input  logic [AW-1:0] wr_val,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic          wrap_evt
);
  import trb_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign wrap_evt = store_evt && (wp == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wp <= '0;
    else if (wp_wr)     wp <= wr_val;
    else if (store_evt) wp <= AW'(ring_step(32'(wp), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rp <= '0;
    else if (rp_wr)      rp <= wr_val;
    else if (rd_adv_evt) rp <= AW'(ring_step(32'(rp), DEPTH));
  end

endmodule

// File: rtl/trb_acq_ctrl.sv
module trb_acq_ctrl #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_valid,
  input  logic             cap_trigger,
  input  logic             ctrl_wr,
  input  logic [1:0]       ctrl_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             wrap_evt,
  output logic             en_q,
  output logic             demux_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             full_q,
  output logic             trig_q,
  output logic             acq_q,
  output logic             flush_q,
  output logic             store_evt,
  output logic             done_evt,
  output logic             clr_evt
);

  logic armed, cnt_zero, cnt_last, trig_seen;

  assign trig_seen = en_q && cap_trigger;
  assign armed     = trig_q || trig_seen;
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == CNT_W'(1));
  assign store_evt = en_q && cap_valid && !(armed && cnt_zero);
  assign done_evt  = en_q && armed && (cnt_zero || (cap_valid && cnt_last));
  assign clr_evt   = ctrl_wr && ctrl_val[0] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      demux_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q    <= ctrl_val[0];
      demux_q <= ctrl_val[1];
    end else if (done_evt) begin
      en_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (cnt_wr)             cnt_q <= cnt_val;
    else if (store_evt && armed) cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      acq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else if (clr_evt) begin
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      acq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (wrap_evt)  full_q  <= 1'b1;
      if (trig_seen) trig_q  <= 1'b1;
      if (done_evt)  acq_q   <= 1'b1;
      if (acq_q)     flush_q <= 1'b1;
    end
  end

endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h5A71_0C3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_trigger,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata
);
  import trb_pkg::*;

  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = 32;

  // named internal events
  logic store_evt, wrap_evt, done_evt, clr_evt, rd_adv_evt;
  logic wp_wr, rp_wr, ctrl_wr, cnt_wr;
  logic cap_en, demux, full_flag, trig_flag, acq_flag, flush_flag;
  logic [AW-1:0]     wp, rp;
  logic [CNT_W-1:0]  trig_cnt;
  logic [DATA_W-1:0] ram_rdata;

  assign wp_wr      = reg_wr && (reg_addr == A_WRPTR);
  assign rp_wr      = reg_wr && (reg_addr == A_RDPTR);
  assign ctrl_wr    = reg_wr && (reg_addr == A_CTRL);
  assign cnt_wr     = reg_wr && (reg_addr == A_TRIGCNT);
  assign rd_adv_evt = reg_rd && (reg_addr == A_DATA);

  trb_acq_ctrl #(.CNT_W(CNT_W)) i_acq (
    .clk(clk), .rst_n(rst_n),
    .cap_valid(cap_valid), .cap_trigger(cap_trigger),
    .ctrl_wr(ctrl_wr), .ctrl_val(reg_wdata[1:0]),
    .cnt_wr(cnt_wr), .cnt_val(CNT_W'(reg_wdata)),
    .wrap_evt(wrap_evt),
    .en_q(cap_en), .demux_q(demux), .cnt_q(trig_cnt),
    .full_q(full_flag), .trig_q(trig_flag), .acq_q(acq_flag), .flush_q(flush_flag),
    .store_evt(store_evt), .done_evt(done_evt), .clr_evt(clr_evt)
  );

  trb_pointers #(.DEPTH(DEPTH), .AW(AW)) i_ptr (
    .clk(clk), .rst_n(rst_n),
    .store_evt(store_evt), .rd_adv_evt(rd_adv_evt),
    .wp_wr(wp_wr), .rp_wr(rp_wr), .wr_val(reg_wdata[AW-1:0]),
    .wp(wp), .rp(rp), .wrap_evt(wrap_evt)
  );

  trb_ring_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) i_ram (
    .clk(clk), .we(store_evt), .waddr(wp), .wdata(cap_data),
    .raddr(rp), .rdata(ram_rdata)
  );

  always_comb begin
    case (reg_addr)
      A_IDENT:   reg_rdata = ID_VALUE;
      A_DEPTH:   reg_rdata = 32'(DEPTH);
      A_WIDTH:   reg_rdata = 32'(DATA_W);
      A_STATUS:  reg_rdata = pack_status(full_flag, trig_flag, acq_flag, flush_flag);
      A_DATA:    reg_rdata = 32'(ram_rdata);
      A_RDPTR:   reg_rdata = 32'(rp);
      A_WRPTR:   reg_rdata = 32'(wp);
      A_TRIGCNT: reg_rdata = 32'(trig_cnt);
      A_CTRL:    reg_rdata = {30'd0, demux, cap_en};
      default:   reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          store_evt,
  input logic          wrap_evt,
  input logic          done_evt,
  input logic          clr_evt,
  input logic          rd_adv_evt,
  input logic          wp_wr,
  input logic          rp_wr,
  input logic          ctrl_wr,
  input logic          cap_en,
  input logic          full_flag,
  input logic          trig_flag,
  input logic          acq_flag,
  input logic          flush_flag,
  input logic [AW-1:0] wp,
  input logic [AW-1:0] rp
);

  // R2
  store_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |-> cap_en);

  // R3
  wp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && !wp_wr) |=> (wp == AW'($past(wp) + 1'b1)));

  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> full_flag);

  // R4
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && !clr_evt) |=> full_flag);

  // R5
  rp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_evt && !rp_wr) |=> (rp == AW'($past(rp) + 1'b1)));

  // R7
  done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !ctrl_wr) |=> (!cap_en && acq_flag));

  // R8
  flush_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_flag && !clr_evt) |=> flush_flag);

  // R8
  flush_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_flag) |-> !flush_flag);

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !(full_flag || trig_flag || acq_flag || flush_flag));

endmodule

bind trace_ring_buffer trb_checker #(.AW(AW)) i_trb_checker (
  .clk(clk), .rst_n(rst_n),
  .store_evt(store_evt), .wrap_evt(wrap_evt), .done_evt(done_evt),
  .clr_evt(clr_evt), .rd_adv_evt(rd_adv_evt),
  .wp_wr(wp_wr), .rp_wr(rp_wr), .ctrl_wr(ctrl_wr),
  .cap_en(cap_en), .full_flag(full_flag), .trig_flag(trig_flag),
  .acq_flag(acq_flag), .flush_flag(flush_flag),
  .wp(wp), .rp(rp)
);

// File: tb/test_trace_ring_buffer.sv
`timescale 1ns/1ps
module test_trace_ring_buffer;

  localparam int unsigned D   = 16;
  localparam logic [31:0] IDV = 32'h5A71_0C3E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [31:0] cap_data = '0;
  logic        cap_trigger = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  trace_ring_buffer i_trace_ring_buffer (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_trigger(cap_trigger), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [31:0] m_ram [D];
  logic [3:0]  m_wp, m_rp;
  logic [31:0] m_cnt;
  logic        m_en, m_dmx, m_full, m_trig, m_acq, m_flush;

  function automatic logic [31:0] exp_rd(input logic [6:0] a);
    case (a)
      7'd0: return IDV;
      7'd1: return 32'(D);
      7'd2: return 32'd32;
      7'd3: return {28'd0, m_flush, m_acq, m_trig, m_full};
      7'd4: return m_ram[m_rp];
      7'd5: return {28'd0, m_rp};
      7'd6: return {28'd0, m_wp};
      7'd7: return m_cnt;
      7'd8: return {30'd0, m_dmx, m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] a);
    case (a)
      7'd3: return "R4";
      7'd4: return "R5";
      7'd5: return "R5";
      7'd6: return "R3";
      7'd7: return "R7";
      7'd8: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic model_step(input logic v, input logic [31:0] d, input logic t,
                            input logic w, input logic [6:0] a, input logic [31:0] wd,
                            input logic r);
    logic armed, zero, store, done, clr;
    armed = m_trig | (m_en & t);
    zero  = (m_cnt == 0);
    store = m_en & v & ~(armed & zero);
    done  = m_en & armed & (zero | (v & (m_cnt == 1)));
    clr   = w & (a == 7'd8) & wd[0] & ~m_en;
    if (store) m_ram[m_wp] = d;
    if (clr) begin
      m_full = 0; m_trig = 0; m_acq = 0; m_flush = 0;
    end else begin
      if (m_acq) m_flush = 1;
      if (done) m_acq = 1;
      if (m_en & t) m_trig = 1;
      if (store && m_wp == 4'(D - 1)) m_full = 1;
    end
    if (w && a == 7'd7) m_cnt = wd;
    else if (store & armed) m_cnt = m_cnt - 1;
    if (w && a == 7'd8) begin m_en = wd[0]; m_dmx = wd[1]; end
    else if (done) m_en = 0;
    if (w && a == 7'd6) m_wp = wd[3:0];
    else if (store) m_wp = m_wp + 4'd1;
    if (w && a == 7'd5) m_rp = wd[3:0];
    else if (r && a == 7'd4) m_rp = m_rp + 4'd1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, sample read data, update reference
  task automatic cyc(input logic v, input logic [31:0] d, input logic t,
                     input logic w, input logic [6:0] a, input logic [31:0] wd,
                     input logic r, output logic [31:0] q);
    @(negedge clk);
    cap_valid = v; cap_data = d; cap_trigger = t;
    reg_wr = w; reg_addr = a; reg_wdata = wd; reg_rd = r;
    #1 q = reg_rdata;
    model_step(v, d, t, w, a, wd, r);
    @(posedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] wd);
    logic [31:0] q;
    cyc(0, 0, 0, 1, a, wd, 0, q);
  endtask

  task automatic cap(input logic v, input logic [31:0] d, input logic t);
    logic [31:0] q;
    cyc(v, d, t, 0, 7'd9, 0, 0, q);
  endtask

  task automatic rd_lit(input string tag, input logic [6:0] a, input logic r,
                        input logic [31:0] exp);
    logic [31:0] q;
    cyc(0, 0, 0, 0, a, 0, r, q);
    chk(tag, q, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic [31:0] w [17];
    void'($urandom(32'd7919));
    m_wp = 0; m_rp = 0; m_cnt = 0;
    m_en = 0; m_dmx = 0; m_full = 0; m_trig = 0; m_acq = 0; m_flush = 0;
    for (int i = 0; i < int'(D); i++) m_ram[i] = 'x;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state and constants
    rd_lit("R1 ident", 7'd0, 0, IDV);
    rd_lit("R1 depth", 7'd1, 0, 32'd16);
    rd_lit("R1 width", 7'd2, 0, 32'd32);
    rd_lit("R4 status after reset", 7'd3, 0, 32'd0);
    rd_lit("R2 control after reset", 7'd8, 0, 32'd0);
    rd_lit("R3 wp after reset", 7'd6, 0, 32'd0);
    wr(7'd1, 32'd5);
    wr(7'd0, 32'h1234);
    rd_lit("R1 depth write ignored", 7'd1, 0, 32'd16);
    rd_lit("R1 ident write ignored", 7'd0, 0, IDV);
    rd_lit("R1 unmapped address", 7'd77, 0, 32'd0);

    // R6: trigger while disabled ignored
    cap(1, 32'hDEAD, 1);
    rd_lit("R6 trigger while disabled", 7'd3, 0, 32'd0);
    rd_lit("R2 no store while disabled", 7'd6, 0, 32'd0);

    // wrap and full, then drain
    for (int i = 0; i < 17; i++) w[i] = $urandom;
    wr(7'd7, 32'd100);
    wr(7'd8, 32'd1);
    for (int i = 0; i < 16; i++) cap(1, w[i], 0);
    rd_lit("R4 full after wrap", 7'd3, 0, 32'd1);
    cap(1, w[16], 0);
    cap(0, 32'hFFFF, 0);
    rd_lit("R3 wp after 17 stores", 7'd6, 0, 32'd1);
    wr(7'd8, 32'd0);
    cap(1, 32'hBEEF, 0);
    rd_lit("R2 stop by writing 0", 7'd6, 0, 32'd1);
    rd_lit("R4 full sticky", 7'd3, 0, 32'd1);
    wr(7'd5, 32'd1);
    for (int i = 0; i < 16; i++) rd_lit("R5 drain oldest first", 7'd4, 1, w[i + 1]);
    rd_lit("R5 rp wrapped", 7'd5, 0, 32'd1);
    rd_lit("R5 strobe elsewhere", 7'd6, 1, 32'd1);
    rd_lit("R5 rp unchanged", 7'd5, 0, 32'd1);
    rd_lit("R2 demux read", 7'd8, 0, 32'd0);
    wr(7'd8, 32'd2);
    rd_lit("R2 demux bit", 7'd8, 0, 32'd2);
    wr(7'd8, 32'd0);

    // post-trigger stop
    wr(7'd6, 32'd0);
    wr(7'd7, 32'd3);
    wr(7'd8, 32'd1);
    rd_lit("R9 flags cleared on enable", 7'd3, 0, 32'd0);
    cap(1, 32'hA0, 0);
    cap(1, 32'hA1, 1);
    rd_lit("R7 counted trigger word", 7'd7, 0, 32'd2);
    cap(0, 32'hA9, 0);
    cap(1, 32'hA2, 0);
    cap(1, 32'hA3, 0);
    rd_lit("R8 complete, not yet flushed", 7'd3, 0, 32'd6);
    rd_lit("R8 flushed next cycle", 7'd3, 0, 32'd14);
    rd_lit("R7 capture disabled", 7'd8, 0, 32'd0);
    rd_lit("R7 last word stored", 7'd6, 0, 32'd4);
    wr(7'd5, 32'd3);
    rd_lit("R7 final word content", 7'd4, 1, 32'hA3);

    // zero counter when armed
    wr(7'd8, 32'd1);
    wr(7'd7, 32'd0);
    cap(1, 32'hC0, 1);
    rd_lit("R7 zero count stops at once", 7'd3, 0, 32'd6);
    rd_lit("R7 zero count stores nothing", 7'd6, 0, 32'd4);

    // R10: same-cycle read and store to one slot
    wr(7'd6, 32'd5);
    wr(7'd5, 32'd5);
    wr(7'd7, 32'd100);
    wr(7'd8, 32'd1);
    cyc(1, 32'h0000_5EED, 0, 0, 7'd4, 0, 1, q);
    chk("R10 read sees old word", q, w[5]);
    rd_lit("R10 rp stepped", 7'd5, 0, 32'd6);
    rd_lit("R10 wp stepped", 7'd6, 0, 32'd6);
    wr(7'd5, 32'd5);
    rd_lit("R10 new word stored", 7'd4, 0, 32'h0000_5EED);
    cyc(1, 32'h77, 0, 1, 7'd6, 32'd9, 0, q);
    rd_lit("R3 pointer write wins", 7'd6, 0, 32'd9);
    wr(7'd8, 32'd0);

    // random mixed traffic against the reference
    for (int i = 0; i < int'(D); i++) m_ram[i] = i_trace_ring_buffer.i_ram.mem[i];
    for (int n = 0; n < 3000; n++) begin
      logic v, t, wflag, rflag;
      logic [6:0] a;
      logic [31:0] d, wd, e;
      int unsigned k;
      k = $urandom % 16;
      v = ($urandom % 4) != 0;
      t = ($urandom % 24) == 0;
      d = $urandom;
      a = 7'($urandom % 10);
      wflag = (k == 8 || k == 9);
      rflag = (k >= 10);
      wd = $urandom;
      if (a == 7'd7) wd = wd % 24;
      if (a == 7'd8) wd = (wd % 8 == 0) ? 32'd0 : {30'd0, wd[1], 1'b1};
      e = exp_rd(a);
      cyc(v, d, t, wflag, a, wd, rflag, q);
      if (!(a == 7'd4 && $isunknown(e))) chk(tag_of(a), q, e);
      if (!m_en && ($urandom % 4 == 0)) begin
        wr(7'd7, $urandom % 24);
        wr(7'd8, 32'd1);
      end
    end

    @(negedge clk);
    cap_valid = 0; reg_wr = 0; reg_rd = 0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule